// File: doc/BRIEF.md
# Debug stimulus port register front-end

This block is the software-facing register front-end of a trace source. Software writes a 32-bit word to one of 32 stimulus port registers. If the write passes every gate, the block pushes the port number and the data word as one entry onto a small output queue. A downstream packet formatter drains that queue through a valid/ready handshake. The block also holds the per-port enable mask, the per-group privilege mask and a control register.

The block starts out locked. Writing the unlock key to a dedicated lock access register opens it. While locked, the block drops every write except a write to the lock access register, and all reads still work.

A stimulus write is accepted only when all of these hold:
- the component is unlocked;
- the master enable is on;
- the target port's enable bit is set;
- either the access is privileged or the privilege bit of the port's group is clear.

When the queue is full, an otherwise acceptable stimulus write is not dropped. It is stalled by a bus wait signal until space frees up.

The register bus is single-cycle. A write takes effect on the rising edge where `busWrite` is high and `busWait` is low. Read data is combinational while `busRead` is high.

Top module: `stim_trace_regs`

## Requirements
- R1: After reset the component is locked, the enable mask, privilege mask, control register and every stimulus register read 0, `outValid` is 0, and the lock status register reads 0x3.
- R2: A write of 0xC5ACCE55 to offset 0xFB0 unlocks; a write of any other value there locks. The lock status register at 0xFB4 reads bit 0 = 1, bit 1 = locked state, bit 2 = 0, and all other bits 0.
- R3: While locked, writes to every register except 0xFB0 have no effect, including stimulus writes; reads still return register contents.
- R4: The control register at 0xE80 stores only the writable bits given by mask 0x007F0F1F: bits 22:16, 11:10, 9:8 and 4:0, with bit 0 as master enable. Bit 23 reads as busy and ignores writes.
- R5: With master enable (control bit 0) clear, writes to the stimulus registers and to the enable mask have no effect.
- R6: The enable mask at 0xE00 holds bit p for port p. A stimulus write to a port whose bit is clear is dropped.
- R7: The privilege mask at 0xE40 holds 4 bits, and bit g covers ports 8g to 8g+7. An unprivileged stimulus write to a port whose group bit is set is dropped. A privileged write to the same port is accepted.
- R8: Stimulus port p sits at offset 4p (0x000 to 0x07C). Each accepted write is queued as {port, data}, and the queue delivers entries in write order. A read of a stimulus register returns the last data accepted for that port.
- R9: Busy (control bit 23) and `outValid` are 1 exactly while the queue is non-empty.
- R10: When the queue is full, an otherwise acceptable stimulus write raises `busWait` and is held, not lost. It is accepted once an entry drains.
- R11: While `outValid` is 1 and `outReady` is 0, `outValid`, `outPort` and `outData` stay unchanged.
- R12: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 12 | Byte address of the access |
| busWrite | input | 1 | Write request |
| busRead | input | 1 | Read request |
| busWdata | input | 32 | Write data |
| busPriv | input | 1 | Access is privileged |
| busRdata | output | 32 | Read data, valid while busRead is high |
| busWait | output | 1 | Write must be held; queue is full |
| outValid | output | 1 | Queue head is valid |
| outReady | input | 1 | Consumer takes the head entry |
| outPort | output | 5 | Port number of the head entry |
| outData | output | 32 | Data word of the head entry |

## Verification
The bench builds the block with its defaults: 32 ports in four privilege groups of eight, and a four-entry queue. With a queue that shallow, four writes held back by a stalled consumer fill it. The fifth write therefore shows the wait stall and the hold of the head entry within a few cycles. Four privilege groups mean that an unprivileged access to group 1 can be dropped while groups 0 and 2 stay open. This places a drop between accepted entries, and the ordered scoreboard catches it if it leaks through.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam logic [31:0] LOCK_KEY      = 32'hC5AC_CE55;
  localparam logic [31:0] OFF_ENABLE    = 32'h0000_0E00;
  localparam logic [31:0] OFF_PRIV      = 32'h0000_0E40;
  localparam logic [31:0] OFF_CTRL      = 32'h0000_0E80;
  localparam logic [31:0] OFF_LOCKKEY   = 32'h0000_0FB0;
  localparam logic [31:0] OFF_LOCKSTAT  = 32'h0000_0FB4;
  localparam logic [31:0] CTRL_WMASK    = 32'h007F_0F1F;
  localparam int          CTRL_BUSY_BIT = 23;
  localparam int          CTRL_MEN_BIT  = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic stimWe;
    logic enWe;
    logic privWe;
    logic ctrlWe;
  } strobe_t;
endpackage

// File: rtl/stp_ctrl.sv
module stp_ctrl #(
  parameter int NUM_PORTS  = 32,
  parameter int GROUP_SIZE = 8,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  localparam int PORT_W    = $clog2(NUM_PORTS),
  localparam int GRP_SHIFT = $clog2(GROUP_SIZE),
  localparam int NUM_GRPS  = NUM_PORTS / GROUP_SIZE,
  localparam int GRP_W     = PORT_W - GRP_SHIFT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrite,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic                  busPriv,
  input  logic                  masterEn,
  input  logic [NUM_PORTS-1:0]  enMask,
  input  logic [NUM_GRPS-1:0]   privMask,
  input  logic                  queueFull,
  output stp_pkg::strobe_t      strobes,
  output logic [PORT_W-1:0]     portIdx,
  output logic                  locked,
  output logic                  busWait
);
  import stp_pkg::*;

  localparam logic [ADDR_W-1:0] STIM_SPAN = ADDR_W'(NUM_PORTS * 4);
  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_PRIV    = ADDR_W'(OFF_PRIV);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_LOCKKEY = ADDR_W'(OFF_LOCKKEY);

  logic             isStim;
  logic [GRP_W-1:0] groupIdx;
  logic             privBlock;
  logic             stimPass;
  logic             open;
  logic             keyWrite;

  assign isStim    = busAddr < STIM_SPAN;
  assign portIdx   = busAddr[PORT_W+1:2];
  assign groupIdx  = portIdx[PORT_W-1:GRP_SHIFT];
  assign privBlock = privMask[groupIdx] && !busPriv;
  assign open      = busWrite && !locked;
  assign keyWrite  = busWrite && (busAddr == A_LOCKKEY);

  // full gate stack for a stimulus write, independent of queue space
  assign stimPass = open && isStim && masterEn && enMask[portIdx] && !privBlock;

  assign busWait         = stimPass && queueFull;
  assign strobes.stimWe  = stimPass && !queueFull;
  assign strobes.enWe    = open && masterEn && (busAddr == A_ENABLE);
  assign strobes.privWe  = open && (busAddr == A_PRIV);
  assign strobes.ctrlWe  = open && (busAddr == A_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         locked <= 1'b1;
    else if (keyWrite) locked <= (busWdata != DATA_W'(LOCK_KEY));
  end

  assert_locked_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !(strobes.stimWe || strobes.enWe || strobes.privWe || strobes.ctrlWe));

  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrite && busWdata == DATA_W'(LOCK_KEY)) |=> !locked);

  assert_bad_key_locks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrite && busWdata != DATA_W'(LOCK_KEY)) |=> locked);

  assert_priv_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stimWe && !busPriv) |-> !privMask[groupIdx]);

  assert_wait_needs_full_R10: assert property (@(posedge clk) disable iff (!rstN)
    busWait |-> (queueFull && !strobes.stimWe));
endmodule

// File: rtl/stp_dpath.sv
module stp_dpath #(
  parameter int NUM_PORTS   = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int QUEUE_DEPTH = 4,
  localparam int PORT_W     = $clog2(NUM_PORTS),
  localparam int NUM_GRPS   = NUM_PORTS / GROUP_SIZE,
  localparam int PTR_W      = $clog2(QUEUE_DEPTH),
  localparam int CNT_W      = PTR_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  stp_pkg::strobe_t      strobes,
  input  logic [PORT_W-1:0]     portIdx,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busRead,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic                  locked,
  input  logic                  outReady,
  output logic                  masterEn,
  output logic [NUM_PORTS-1:0]  enMask,
  output logic [NUM_GRPS-1:0]   privMask,
  output logic                  queueFull,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  outValid,
  output logic [PORT_W-1:0]     outPort,
  output logic [DATA_W-1:0]     outData
);
  import stp_pkg::*;

  localparam logic [ADDR_W-1:0] STIM_SPAN  = ADDR_W'(NUM_PORTS * 4);
  localparam logic [ADDR_W-1:0] A_ENABLE   = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_PRIV     = ADDR_W'(OFF_PRIV);
  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_LOCKSTAT = ADDR_W'(OFF_LOCKSTAT);

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] stimLast [NUM_PORTS];
  logic [PORT_W-1:0] memPort  [QUEUE_DEPTH];
  logic [DATA_W-1:0] memData  [QUEUE_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              push, pop;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      enMask   <= '0;
      privMask <= '0;
    end else begin
      if (strobes.ctrlWe) ctrlReg  <= busWdata & DATA_W'(CTRL_WMASK);
      if (strobes.enWe)   enMask   <= busWdata[NUM_PORTS-1:0];
      if (strobes.privWe) privMask <= busWdata[NUM_GRPS-1:0];
    end
  end

  assign masterEn = ctrlReg[CTRL_MEN_BIT];

  // last accepted word per port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_stim
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       stimLast[p] <= '0;
      else if (strobes.stimWe && portIdx == PORT_W'(p)) stimLast[p] <= busWdata;
    end
  end

  // output queue
  assign push      = strobes.stimWe;
  assign outValid  = count != '0;
  assign pop       = outValid && outReady;
  assign queueFull = count == CNT_W'(QUEUE_DEPTH);
  assign outPort   = memPort[rdPtr];
  assign outData   = memData[rdPtr];

  always_ff @(posedge clk) begin
    if (push) begin
      memPort[wrPtr] <= portIdx;
      memData[wrPtr] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // read mux
  always_comb begin
    busRdata = '0;
    if (busRead) begin
      if (busAddr < STIM_SPAN)          busRdata = stimLast[portIdx];
      else if (busAddr == A_ENABLE)     busRdata = DATA_W'(enMask);
      else if (busAddr == A_PRIV)       busRdata = DATA_W'(privMask);
      else if (busAddr == A_CTRL) begin
        busRdata = ctrlReg;
        busRdata[CTRL_BUSY_BIT] = outValid;
      end
      else if (busAddr == A_LOCKSTAT)   busRdata = DATA_W'({1'b0, locked, 1'b1});
    end
  end

  assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !queueFull);

  assert_head_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outPort) && $stable(outData)));

  assert_valid_from_push_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(push));

  assert_lockstat_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == A_LOCKSTAT) |-> (busRdata[0] && !busRdata[2]));
endmodule

// File: rtl/stim_trace_regs.sv
module stim_trace_regs #(
  parameter int NUM_PORTS   = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int QUEUE_DEPTH = 4,
  localparam int PORT_W     = $clog2(NUM_PORTS),
  localparam int NUM_GRPS   = NUM_PORTS / GROUP_SIZE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busPriv,
  output logic [DATA_W-1:0] busRdata,
  output logic              busWait,
  output logic              outValid,
  input  logic              outReady,
  output logic [PORT_W-1:0] outPort,
  output logic [DATA_W-1:0] outData
);
  stp_pkg::strobe_t     strobes;
  logic [PORT_W-1:0]    portIdx;
  logic                 locked;
  logic                 masterEn;
  logic [NUM_PORTS-1:0] enMask;
  logic [NUM_GRPS-1:0]  privMask;
  logic                 queueFull;

  stp_ctrl #(
    .NUM_PORTS(NUM_PORTS), .GROUP_SIZE(GROUP_SIZE),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busPriv(busPriv), .masterEn(masterEn),
    .enMask(enMask), .privMask(privMask), .queueFull(queueFull),
    .strobes(strobes), .portIdx(portIdx), .locked(locked), .busWait(busWait)
  );

  stp_dpath #(
    .NUM_PORTS(NUM_PORTS), .GROUP_SIZE(GROUP_SIZE), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .QUEUE_DEPTH(QUEUE_DEPTH)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .portIdx(portIdx),
    .busAddr(busAddr), .busRead(busRead), .busWdata(busWdata),
    .locked(locked), .outReady(outReady), .masterEn(masterEn),
    .enMask(enMask), .privMask(privMask), .queueFull(queueFull),
    .busRdata(busRdata), .outValid(outValid), .outPort(outPort),
    .outData(outData)
  );
endmodule

// File: tb/stim_trace_regs_tb_top.sv
module stim_trace_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrite = 1'b0, busRead = 1'b0, busPriv = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busWait, outValid;
  logic        outReady = 1'b0;
  logic [4:0]  outPort;
  logic [31:0] outData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic [36:0] expQ [$];

  always #2 clk = ~clk;  // 250 MHz

  stim_trace_regs dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busPriv(busPriv),
    .busRdata(busRdata), .busWait(busWait), .outValid(outValid),
    .outReady(outReady), .outPort(outPort), .outData(outData)
  );

  task automatic chk(input bit ok, input string tag, input logic [36:0] act, input logic [36:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    #1;
    chk(busRdata == exp, tag, 37'(busRdata), 37'(exp));
    busRead = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit priv, input bit expPush);
    @(negedge clk);
    busAddr = a; busWdata = d; busPriv = priv; busWrite = 1'b1;
    if (expPush) expQ.push_back({a[6:2], d});
    #1;
    while (busWait) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    busWrite = 1'b0; busPriv = 1'b0;
  endtask

  task automatic setReady(input logic v);
    @(posedge clk); #1;
    outReady = v;
  endtask

  // scoreboard monitor (R8)
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0)
        chk(1'b0, "R8 unexpected queue entry", {outPort, outData}, '0);
      else begin
        logic [36:0] e;
        e = expQ.pop_front();
        chk({outPort, outData} == e, "R8 queue order/content", {outPort, outData}, e);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [36:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    rd(12'hFB4, 32'h3, "R1 lock status after reset");
    rd(12'hE80, 32'h0, "R1 control after reset");
    rd(12'hE00, 32'h0, "R1 enable after reset");
    rd(12'hE40, 32'h0, "R1 privilege after reset");
    rd(12'h000, 32'h0, "R1 stim0 after reset");
    chk(outValid == 1'b0, "R1 outValid after reset", 37'(outValid), 37'd0);

    // R3 locked writes ignored
    wr(12'hE80, 32'h1, 1'b1, 1'b0);
    rd(12'hE80, 32'h0, "R3 control write while locked");

    // R2 unlock
    wr(12'hFB0, 32'hC5AC_CE55, 1'b0, 1'b0);
    rd(12'hFB4, 32'h1, "R2 lock status after key");

    // R5 master enable off
    wr(12'h00C, 32'hDEAD_0003, 1'b1, 1'b0);
    wr(12'hE00, 32'hFFFF_FFFF, 1'b1, 1'b0);
    rd(12'h00C, 32'h0, "R5 stim write with master off");
    rd(12'hE00, 32'h0, "R5 enable write with master off");
    chk(outValid == 1'b0, "R5 nothing queued", 37'(outValid), 37'd0);

    // R4 control write mask, busy clear when empty
    wr(12'hE80, 32'hFFFF_FFFF, 1'b0, 1'b0);
    rd(12'hE80, 32'h007F_0F1F, "R4 control writable bits");

    // R6 enable mask
    wr(12'hE00, 32'h0000_FF0F, 1'b0, 1'b0);
    rd(12'hE00, 32'h0000_FF0F, "R6 enable readback");

    // R7 privilege group 1 (ports 8..15)
    wr(12'hE40, 32'h0000_0002, 1'b0, 1'b0);
    rd(12'hE40, 32'h2, "R7 privilege readback");

    // fill queue with consumer stalled
    wr(12'h000, 32'hAAAA_0000, 1'b0, 1'b1);
    wr(12'h004, 32'hBBBB_0001, 1'b0, 1'b1);
    wr(12'h010, 32'h4444_0004, 1'b0, 1'b0);   // R6 port 4 disabled
    wr(12'h024, 32'h9999_0009, 1'b0, 1'b0);   // R7 unprivileged, group 1
    wr(12'h028, 32'hCCCC_000A, 1'b1, 1'b1);   // R7 privileged, group 1
    wr(12'h008, 32'hDDDD_0002, 1'b0, 1'b1);
    rd(12'h010, 32'h0, "R6 disabled port not written");
    rd(12'h024, 32'h0, "R7 unprivileged write dropped");
    rd(12'hE80, 32'h00FF_0F1F, "R9 busy set with entries pending");
    chk(outValid == 1'b1, "R9 outValid with entries", 37'(outValid), 37'd1);

    // R10 stall on full queue, R11 head holds
    @(negedge clk);
    busAddr = 12'h00C; busWdata = 32'hEEEE_0003; busWrite = 1'b1;
    expQ.push_back({5'd3, 32'hEEEE_0003});
    #1;
    chk(busWait == 1'b1, "R10 busWait when full", 37'(busWait), 37'd1);
    held = {outPort, outData};
    @(negedge clk); #1;
    chk({outPort, outData} == held, "R11 head stable while stalled", {outPort, outData}, held);
    chk(busWait == 1'b1, "R10 busWait held", 37'(busWait), 37'd1);
    fork
      setReady(1'b1);
    join_none
    while (busWait) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    busWrite = 1'b0;

    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R9 outValid clear after drain", 37'(outValid), 37'd0);
    chk(expQ.size() == 0, "R8 all expected entries delivered", 37'(expQ.size()), 37'd0);
    rd(12'hE80, 32'h007F_0F1F, "R9 busy clear after drain");
    rd(12'h000, 32'hAAAA_0000, "R8 stim0 readback");
    rd(12'h028, 32'hCCCC_000A, "R8 stim10 readback");
    rd(12'h00C, 32'hEEEE_0003, "R10 stalled write landed");

    // R2 relock with wrong key, R3 writes ignored
    wr(12'hFB0, 32'h0000_0000, 1'b0, 1'b0);
    rd(12'hFB4, 32'h3, "R2 lock status after bad key");
    wr(12'hE00, 32'h0, 1'b0, 1'b0);
    wr(12'h000, 32'h1234_5678, 1'b1, 1'b0);
    rd(12'hE00, 32'h0000_FF0F, "R3 enable unchanged while locked");
    rd(12'h000, 32'hAAAA_0000, "R3 stim unchanged while locked");
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R3 no queue entry while locked", 37'(outValid), 37'd0);

    // R12 unmapped
    rd(12'h100, 32'h0, "R12 unmapped read");
    rd(12'hF00, 32'h0, "R12 unmapped read high");

    finishRun();
  end
endmodule